// File: doc/BRIEF.md
# PUF Challenge-Capture Sequencer

This block drives a single challenge-response query against a network of free-running logic nodes. A host presents an N-bit challenge, a hold length and a tap index, then pulses a start request. The sequencer latches these values and drives the challenge onto the network while keeping the network's reset asserted for the programmed number of cycles. It then drops reset so the network can evolve freely. The release event travels down a chain of delay stages. Each stage stands for one inverter pair and is modelled here as one clock step. When the event reaches the selected tap, the network state is registered as the response and `done_o` pulses for one cycle. The network then returns to reset with the same challenge applied, so the same query can be repeated at once.

The all-zero and all-one patterns are fixed points of an odd-input XOR network, so they are not accepted as normal challenges. A self-test request runs both patterns in turn: all-zero first, then all-one. If either captured response differs from its own challenge, a sticky fault flag is set, which marks the instance as unstable.

Top module: `puf_capture_seq`

## Requirements
- R1: After reset the outputs are `net_hold_o`=1, `done_o`=0, `busy_o`=0, `fault_o`=0, `response_o`=0 and `net_challenge_o`=0.
- R2: A start accepted in idle latches the challenge onto `net_challenge_o`. It keeps `net_hold_o` high until the hold count has elapsed, then drives `net_hold_o` low to release the network.
- R3: With tap index T, `net_hold_o` stays low for exactly T+1 cycles. `response_o` takes the value `net_state_i` had in the last of those cycles, so tap 0 samples the first step after release.
- R4: `done_o` is a single-cycle pulse that rises H+T+2 clock edges after the edge that accepts start, where H is the effective hold length. On the edge after the pulse, `busy_o` returns low.
- R5: A hold length of 0 is treated as 1.
- R6: After capture, `net_hold_o` returns high with the same challenge still on `net_challenge_o`, and repeating the query gives the same response.
- R7: A start or self-test request while `busy_o` is high is ignored: the challenge, the response and the timing of the running query are unchanged, and no extra `done_o` follows.
- R8: A normal start whose challenge is all-zero or all-one is ignored, and `busy_o` stays low.
- R9: A self-test runs the all-zero query and then the all-one query, with the same hold and tap. Its `done_o` rises 2H+2T+4 edges after acceptance, and `response_o` then holds the all-one capture.
- R10: A self-test sets `fault_o` if either capture differs from its challenge. `fault_o` stays set until the next self-test is accepted, which clears it.
- R11: When start and self-test are requested in the same idle cycle, the self-test wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a normal query |
| selftest_i | input | 1 | Request the fixed-point self-test |
| challenge_i | input | N | Challenge for a normal query |
| hold_cycles_i | input | HW | Cycles to hold the network in reset (0 means 1) |
| tap_sel_i | input | TW | Delay tap at which to capture |
| net_state_i | input | N | Booleanized network state |
| net_hold_o | output | 1 | Network reset, high = challenge forced |
| net_challenge_o | output | N | Challenge applied to the network |
| response_o | output | N | Captured response |
| done_o | output | 1 | One-cycle pulse when response_o is valid |
| busy_o | output | 1 | Query or self-test in progress |
| fault_o | output | 1 | Sticky self-test failure flag |

## Verification
The bench builds the block with N=16, TAPS=16 and HW=4. With these values, every hold length from 0 to the maximum of 15 and every tap from 0 to the last stage can be reached in short runs. The external network is modelled as a clocked 3-input XOR ring, so each expected response is that ring iterated T steps from the challenge. A mask can be forced onto the network state while it runs free, which lets the bench drive both passing and failing self-tests. The bench also sends requests mid-query, reserved challenges and simultaneous requests to cover the ignore and priority rules.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE      = 3'd0,
    SEQ_LOAD_HOLD = 3'd1,
    SEQ_RUN       = 3'd2,
    SEQ_CAPTURE   = 3'd3,
    SEQ_DONE      = 3'd4
  } seq_state_t;
endpackage

// File: rtl/puf_hold_timer.sv
module puf_hold_timer #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          count_en,
  input  logic [HW-1:0] limit,
  output logic          expired
);
  // zero hold behaves as a single cycle (R5)
  function automatic logic [HW-1:0] eff_len(input logic [HW-1:0] l);
    return (l == '0) ? HW'(1) : l;
  endfunction

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = count_en && (cnt_q == eff_len(limit) - HW'(1));
endmodule

// File: rtl/puf_tap_line.sv
module puf_tap_line #(
  parameter int TAPS = 16,
  parameter int TW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          flush,
  input  logic [TW-1:0] tap_sel,
  output logic          fire
);
  logic [TAPS-1:0] stage_q;
  logic [TAPS-1:0] stage_d;
  logic [TW-1:0]   sel;

  // each stage stands for one inverter pair
  for (genvar gi = 0; gi < TAPS; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      assign stage_d[gi] = flush ? 1'b0 : launch;
    end else begin : g_body
      assign stage_d[gi] = flush ? 1'b0 : stage_q[gi-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sel  = (int'(tap_sel) > TAPS - 1) ? TW'(TAPS - 1) : tap_sel;
  assign fire = stage_q[sel];
endmodule

// File: rtl/puf_fixpoint_check.sv
module puf_fixpoint_check #(
  parameter int N = 32
) (
  input  logic [N-1:0] resp,
  input  logic         phase,
  output logic         mismatch
);
  assign mismatch = (resp != {N{phase}});
endmodule

// File: rtl/puf_capture_seq.sv
module puf_capture_seq #(
  parameter int N    = 32,
  parameter int TAPS = 16,
  parameter int HW   = 8,
  localparam int TW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          selftest_i,
  input  logic [N-1:0]  challenge_i,
  input  logic [HW-1:0] hold_cycles_i,
  input  logic [TW-1:0] tap_sel_i,
  input  logic [N-1:0]  net_state_i,
  output logic          net_hold_o,
  output logic [N-1:0]  net_challenge_o,
  output logic [N-1:0]  response_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          fault_o
);
  import puf_seq_pkg::*;

  function automatic logic is_fixed_pattern(input logic [N-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  seq_state_t    state_q, state_d;
  logic [N-1:0]  chal_q, resp_q;
  logic [HW-1:0] hold_q;
  logic [TW-1:0] tap_q;
  logic          fault_q, st_mode_q, st_phase_q;

  // named internal events
  logic accept_st, accept_q, release_evt, capture_evt, st_restart;
  logic hold_expired, tap_fire, st_mismatch, st_active;

  assign accept_st   = (state_q == SEQ_IDLE) && selftest_i;
  assign accept_q    = (state_q == SEQ_IDLE) && !selftest_i && start_i
                       && !is_fixed_pattern(challenge_i);
  assign release_evt = (state_q == SEQ_LOAD_HOLD) && hold_expired;
  assign capture_evt = (state_q == SEQ_RUN) && tap_fire;
  assign st_restart  = (state_q == SEQ_CAPTURE) && st_mode_q && !st_phase_q;
  assign st_active   = st_mode_q;

  puf_hold_timer #(.HW(HW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept_st || accept_q || st_restart),
    .count_en (state_q == SEQ_LOAD_HOLD),
    .limit    (hold_q),
    .expired  (hold_expired)
  );

  puf_tap_line #(.TAPS(TAPS), .TW(TW)) line_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (release_evt),
    .flush   (capture_evt),
    .tap_sel (tap_q),
    .fire    (tap_fire)
  );

  puf_fixpoint_check #(.N(N)) fix_i (
    .resp     (resp_q),
    .phase    (st_phase_q),
    .mismatch (st_mismatch)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:      if (accept_st || accept_q) state_d = SEQ_LOAD_HOLD;
      SEQ_LOAD_HOLD: if (release_evt) state_d = SEQ_RUN;
      SEQ_RUN:       if (capture_evt) state_d = SEQ_CAPTURE;
      SEQ_CAPTURE:   state_d = st_restart ? SEQ_LOAD_HOLD : SEQ_DONE;
      SEQ_DONE:      state_d = SEQ_IDLE;
      default:       state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      chal_q     <= '0;
      resp_q     <= '0;
      hold_q     <= '0;
      tap_q      <= '0;
      fault_q    <= 1'b0;
      st_mode_q  <= 1'b0;
      st_phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_st) begin
        chal_q     <= '0;
        st_mode_q  <= 1'b1;
        st_phase_q <= 1'b0;
        fault_q    <= 1'b0;
        hold_q     <= hold_cycles_i;
        tap_q      <= tap_sel_i;
      end else if (accept_q) begin
        chal_q    <= challenge_i;
        st_mode_q <= 1'b0;
        hold_q    <= hold_cycles_i;
        tap_q     <= tap_sel_i;
      end
      if (capture_evt) resp_q <= net_state_i;
      if ((state_q == SEQ_CAPTURE) && st_mode_q) begin
        if (st_mismatch) fault_q <= 1'b1;
        if (!st_phase_q) begin
          st_phase_q <= 1'b1;
          chal_q     <= '1;
        end
      end
      if (state_q == SEQ_DONE) st_mode_q <= 1'b0;
    end
  end

  assign net_hold_o      = (state_q != SEQ_RUN);
  assign net_challenge_o = chal_q;
  assign response_o      = resp_q;
  assign done_o          = (state_q == SEQ_DONE);
  assign busy_o          = (state_q != SEQ_IDLE);
  assign fault_o         = fault_q;
endmodule

// File: rtl/puf_capture_seq_chk.sv
module puf_capture_seq_chk #(
  parameter int N  = 32,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          selftest_i,
  input logic [N-1:0]  challenge_i,
  input logic [N-1:0]  net_state_i,
  input logic          net_hold_o,
  input logic [N-1:0]  net_challenge_o,
  input logic [N-1:0]  response_o,
  input logic          done_o,
  input logic          busy_o,
  input logic          fault_o,
  input logic          release_evt,
  input logic          capture_evt,
  input logic          st_active,
  input logic [TW-1:0] tap_q
);
  // counts cycles of free run independently of the tap line
  logic [TW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (net_hold_o) run_len <= '0;
    else if (run_len != '1) run_len <= run_len + 1'b1;
  end

  assert_release_drops_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !net_hold_o);

  assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (response_o == $past(net_state_i)));

  assert_tap_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (run_len == {1'b0, tap_q}));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  assert_busy_chal_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !st_active && !done_o) |=> $stable(net_challenge_o));

  assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !selftest_i &&
     ((challenge_i == '0) || (challenge_i == '1))) |=> !busy_o);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !selftest_i) |=> $stable(fault_o));
endmodule

bind puf_capture_seq puf_capture_seq_chk #(.N(N), .TW(TW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .selftest_i      (selftest_i),
  .challenge_i     (challenge_i),
  .net_state_i     (net_state_i),
  .net_hold_o      (net_hold_o),
  .net_challenge_o (net_challenge_o),
  .response_o      (response_o),
  .done_o          (done_o),
  .busy_o          (busy_o),
  .fault_o         (fault_o),
  .release_evt     (release_evt),
  .capture_evt     (capture_evt),
  .st_active       (st_active),
  .tap_q           (tap_q)
);

// File: tb/puf_capture_seq_tb_top.sv
`timescale 1ns/1ps
module puf_capture_seq_tb_top;
  localparam int N    = 16;
  localparam int TAPS = 16;
  localparam int HW   = 4;
  localparam int TW   = $clog2(TAPS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          selftest_i = 1'b0;
  logic [N-1:0]  challenge_i = '0;
  logic [HW-1:0] hold_cycles_i = '0;
  logic [TW-1:0] tap_sel_i = '0;
  logic [N-1:0]  net_state_i;
  logic          net_hold_o, done_o, busy_o, fault_o;
  logic [N-1:0]  net_challenge_o, response_o;

  logic [N-1:0]  net_q = '0;
  logic [N-1:0]  glitch = '0;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  puf_capture_seq #(.N(N), .TAPS(TAPS), .HW(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .selftest_i(selftest_i),
    .challenge_i(challenge_i), .hold_cycles_i(hold_cycles_i),
    .tap_sel_i(tap_sel_i), .net_state_i(net_state_i),
    .net_hold_o(net_hold_o), .net_challenge_o(net_challenge_o),
    .response_o(response_o), .done_o(done_o), .busy_o(busy_o),
    .fault_o(fault_o)
  );

  // clocked stand-in for the free-running XOR network
  function automatic logic [N-1:0] net_next(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = v[(i + 1) % N] ^ v[(i + 3) % N] ^ v[(i + 6) % N];
    return r;
  endfunction

  function automatic logic [N-1:0] expect_resp(input logic [N-1:0] c, input int t,
                                               input logic [N-1:0] m);
    logic [N-1:0] v = c;
    for (int k = 0; k < t; k++) v = net_next(v);
    return v ^ m;
  endfunction

  function automatic int eff_hold(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  always @(posedge clk) net_q <= net_hold_o ? net_challenge_o : net_next(net_q);
  assign net_state_i = net_q ^ (net_hold_o ? '0 : glitch);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // request, then wait for done; cyc counts negedges after the accepting edge
  task automatic run_req(input bit st, input bit both, input logic [N-1:0] c,
                         input int h, input int t, input bit poke,
                         output int cyc, output int lows, output bit seen);
    @(negedge clk);
    challenge_i = c; hold_cycles_i = HW'(h); tap_sel_i = TW'(t);
    start_i = !st || both; selftest_i = st;
    seen = 0; lows = 0; cyc = 0;
    for (int k = 1; k < 300; k++) begin
      @(negedge clk);
      if (k == 1) begin start_i = 0; selftest_i = 0; end
      if (poke && k == 2) begin start_i = 1; selftest_i = 1; challenge_i = c ^ N'(5); end
      if (poke && k == 3) begin start_i = 0; selftest_i = 0; end
      if (!net_hold_o) lows++;
      if (done_o) begin seen = 1; cyc = k; break; end
    end
  endtask

  task automatic query(input logic [N-1:0] c, input int h, input int t, input bit poke);
    int cyc, lows; bit seen; bit extra;
    run_req(0, 0, c, h, t, poke, cyc, lows, seen);
    check(seen, "R4 done seen", 64'(seen), 64'(1));
    check(cyc == eff_hold(h) + t + 3, "R4/R5 done timing", 64'(cyc), 64'(eff_hold(h) + t + 3));
    check(lows == t + 1, "R3 release window", 64'(lows), 64'(t + 1));
    check(response_o == expect_resp(c, t, '0), "R3 response",
          64'(response_o), 64'(expect_resp(c, t, '0)));
    check(net_challenge_o == c, "R6 challenge kept", 64'(net_challenge_o), 64'(c));
    @(negedge clk);
    check(!done_o && !busy_o, "R4 single pulse", {62'd0, done_o, busy_o}, 64'd0);
    check(net_hold_o, "R6 back in reset", 64'(net_hold_o), 64'(1));
    if (poke) begin
      extra = 0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (done_o || busy_o) extra = 1; end
      check(!extra, "R7 busy request ignored", 64'(extra), 64'(0));
    end
  endtask

  task automatic selftest(input int h, input int t, input logic [N-1:0] m,
                          input bit both, input logic [N-1:0] c);
    int cyc, lows; bit seen;
    glitch = m;
    run_req(1, both, c, h, t, 0, cyc, lows, seen);
    check(seen && cyc == 2 * eff_hold(h) + 2 * t + 5, "R9/R11 selftest timing",
          64'(cyc), 64'(2 * eff_hold(h) + 2 * t + 5));
    check(lows == 2 * (t + 1), "R9 two releases", 64'(lows), 64'(2 * (t + 1)));
    check(response_o == ('1 ^ m), "R9 all-one capture", 64'(response_o), 64'('1 ^ m));
    check(fault_o == (m != '0), "R10 fault flag", 64'(fault_o), 64'(m != '0));
    glitch = '0;
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] c;
    int h, t;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(net_hold_o && !done_o && !busy_o && !fault_o, "R1 reset flags",
          {60'd0, net_hold_o, done_o, busy_o, fault_o}, 64'b1000);
    check(response_o == '0 && net_challenge_o == '0, "R1 reset data",
          64'(response_o | net_challenge_o), 64'd0);

    // directed corners
    query(N'(16'h1234), 0, 0, 0);          // R5 zero hold, R3 tap 0
    query(N'(16'h1234), 0, 0, 0);          // R6 repeat
    query(N'(16'hbeef), 15, 15, 0);        // maximum hold and tap
    query(N'(16'h00f0), 3, 5, 1);          // R7 poke while busy

    // R8 reserved challenges
    for (int r = 0; r < 2; r++) begin
      bit moved = 0;
      @(negedge clk);
      challenge_i = r ? '1 : '0; start_i = 1;
      @(negedge clk); start_i = 0;
      for (int k = 0; k < 6; k++) begin
        if (busy_o || done_o) moved = 1;
        @(negedge clk);
      end
      check(!moved, "R8 reserved ignored", 64'(moved), 64'(0));
      check(net_challenge_o == N'(16'h00f0), "R8 challenge unchanged",
            64'(net_challenge_o), 64'(16'h00f0));
    end

    selftest(2, 3, '0, 0, '0);             // clean pass
    selftest(1, 0, N'(16'h0100), 0, '0);   // glitched, fault
    query(N'(16'h0a0a), 2, 4, 0);
    check(fault_o, "R10 fault sticky", 64'(fault_o), 64'(1));
    selftest(4, 2, '0, 1, N'(16'h3c3c));   // R11 both requested, clears fault

    // constrained random queries
    for (int n = 0; n < 24; n++) begin
      c = N'($urandom);
      if (c == '0 || c == '1) c = c ^ N'(1);
      h = int'($urandom % 16);
      t = int'($urandom % TAPS);
      query(c, h, t, ($urandom % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule